// File: doc/BRIEF.md
# Dual Masked Calendar Alarm

This block keeps two independent alarm register sets and compares each of them with the live calendar time: seconds, minutes, hours, date, month and day of week, all in BCD. Every compare field carries its own enable bit, and only enabled fields take part in the match. Enabling every field gives a one-shot calendar alarm. Enabling only some fields gives a repeating alarm; for example, enabling only the seconds field makes the alarm fire once a minute.

The match is evaluated once per time-advance strobe `tick`. On the cycle of that strobe, the time inputs already carry the new time. A match sets a sticky per-alarm flag and raises a one-cycle interrupt pulse. The host loads the alarm registers through a simple write port. It clears flags with a masked clear strobe. A match in the same cycle as a clear wins over the clear. Each alarm also stores a year byte, which is never compared.

Top module: `calAlarm`

## Requirements
- R1: After reset, `flags` is 00, `irqPulse` is 0 and every alarm field is disabled.
- R2: A cycle with `wrEn` high loads `wrData` into the register chosen by `wrAlarm` (0 or 1) and `wrField`. The `wrField` codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week and 6 year. Within each register, bit 7 is the field enable and bits 6:0 are the BCD compare value.
- R3: On a cycle with `tick` high where every enabled field of alarm n equals its time input, `flags[n]` reads 1 from the next cycle on.
- R4: Disabled fields do not affect the match. An alarm with only the seconds field enabled fires on every tick whose seconds input equals that value, whatever the other fields hold.
- R5: An alarm with no enabled field never fires.
- R6: The stored year value has no effect on the match.
- R7: Time inputs that match while `tick` is low set no flag.
- R8: Flags stay set until cleared. A cycle with `clrEn` high clears each flag whose `clrMask` bit is 1, from the next cycle on, and leaves the other flags unchanged.
- R9: When a match of alarm n and a clear of `flags[n]` fall in the same cycle, `flags[n]` stays 1.
- R10: `irqPulse` is high for exactly the one cycle after a tick on which at least one alarm matches, and low otherwise.
- R11: The two alarms are independent. Each flag is set only by a match of its own alarm, and both flags can be set by the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Strobe: the time inputs have just advanced |
| secNow | input | 8 | Current seconds, BCD |
| minNow | input | 8 | Current minutes, BCD |
| hourNow | input | 8 | Current hours, BCD |
| dateNow | input | 8 | Current date, BCD |
| monNow | input | 8 | Current month, BCD |
| dowNow | input | 8 | Current day of week, BCD |
| wrEn | input | 1 | Alarm register write strobe |
| wrAlarm | input | 1 | Alarm select for the write |
| wrField | input | 3 | Register select for the write |
| wrData | input | 8 | Write data: enable in bit 7, BCD value in bits 6:0 |
| clrEn | input | 1 | Flag clear strobe |
| clrMask | input | 2 | Flags to clear |
| flags | output | 2 | Sticky per-alarm match flags |
| irqPulse | output | 1 | One-cycle pulse after a matching tick |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that the time fields are stable during it. They also assume reset is held at time zero, so that a flag rising can always be traced back to a tick in the previous cycle. The stimulus drives every input on the falling clock edge. It raises `tick` for exactly one cycle per time value, and it never writes alarm registers in the same cycle as a tick. This keeps each expected flag value tied to one known register setting.

// File: rtl/calAlarmPkg.sv
package calAlarmPkg;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_CMP    = 6;   // compared fields: sec, min, hour, date, month, dow
  localparam int NUM_REGS   = 7;   // compared fields plus the stored year
  localparam int REG_W      = 8;
  localparam int VAL_W      = REG_W - 1;
  localparam int SEL_W      = $clog2(NUM_REGS);
  localparam int ALM_W      = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;
  localparam int LOAD_W     = NUM_ALARMS * NUM_REGS;

  typedef struct packed {
    logic [LOAD_W-1:0] load;   // one-hot register load strobes
    logic [REG_W-1:0]  data;   // value to load
  } alarmStrobes_t;
endpackage

// File: rtl/alarmDatapath.sv
module alarmDatapath
  import calAlarmPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  alarmStrobes_t                    strb,
  input  logic [NUM_CMP-1:0][REG_W-1:0]    nowVec,
  output logic [NUM_ALARMS-1:0]            hit
);
  logic [NUM_ALARMS-1:0][NUM_REGS-1:0][REG_W-1:0] regFile;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile <= '0;
    end else begin
      for (int a = 0; a < NUM_ALARMS; a++) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          if (strb.load[a*NUM_REGS + r]) regFile[a][r] <= strb.data;
        end
      end
    end
  end

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    logic [NUM_CMP-1:0] fieldOk;
    logic [NUM_CMP-1:0] fieldEn;
    always_comb begin
      for (int f = 0; f < NUM_CMP; f++) begin
        fieldEn[f] = regFile[a][f][REG_W-1];
        fieldOk[f] = !fieldEn[f] ||
                     ({1'b0, regFile[a][f][VAL_W-1:0]} == nowVec[f]);
      end
      hit[a] = (|fieldEn) && (&fieldOk);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      // R2
      load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.load[a*NUM_REGS + r] |=> regFile[a][r] == $past(strb.data));
    end
  end
endmodule

// File: rtl/alarmControl.sv
module alarmControl
  import calAlarmPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ALM_W-1:0]      wrAlarm,
  input  logic [SEL_W-1:0]      wrField,
  input  logic [REG_W-1:0]      wrData,
  input  logic                  tick,
  input  logic [NUM_ALARMS-1:0] hit,
  input  logic                  clrEn,
  input  logic [NUM_ALARMS-1:0] clrMask,
  output alarmStrobes_t         strb,
  output logic [NUM_ALARMS-1:0] flags,
  output logic                  irqPulse
);
  logic [NUM_ALARMS-1:0] newHit;
  logic [NUM_ALARMS-1:0] clrBits;

  always_comb begin
    strb.load = '0;
    strb.data = wrData;
    if (wrEn && (int'(wrField) < NUM_REGS) && (int'(wrAlarm) < NUM_ALARMS))
      strb.load[int'(wrAlarm)*NUM_REGS + int'(wrField)] = 1'b1;
  end

  assign newHit  = tick ? hit : '0;
  assign clrBits = clrEn ? clrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      irqPulse <= 1'b0;
    end else begin
      flags    <= (flags & ~clrBits) | newHit;
      irqPulse <= |newHit;
    end
  end

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    // R7
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> $past(tick));
    // R9
    hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(tick && hit[i]) |-> flags[i]);
    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(clrEn && clrMask[i] && !(tick && hit[i])) |-> !flags[i]);
  end
  // R10
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(tick) && ($countones(flags) > 0));
endmodule

// File: rtl/calAlarm.sv
module calAlarm
  import calAlarmPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [REG_W-1:0] secNow,
  input  logic [REG_W-1:0] minNow,
  input  logic [REG_W-1:0] hourNow,
  input  logic [REG_W-1:0] dateNow,
  input  logic [REG_W-1:0] monNow,
  input  logic [REG_W-1:0] dowNow,
  input  logic             wrEn,
  input  logic [ALM_W-1:0] wrAlarm,
  input  logic [SEL_W-1:0] wrField,
  input  logic [REG_W-1:0] wrData,
  input  logic             clrEn,
  input  logic [NUM_ALARMS-1:0] clrMask,
  output logic [NUM_ALARMS-1:0] flags,
  output logic             irqPulse
);
  alarmStrobes_t                 strb;
  logic [NUM_ALARMS-1:0]         hit;
  logic [NUM_CMP-1:0][REG_W-1:0] nowVec;

  assign nowVec = {dowNow, monNow, dateNow, hourNow, minNow, secNow};

  alarmControl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAlarm(wrAlarm), .wrField(wrField),
    .wrData(wrData), .tick(tick), .hit(hit), .clrEn(clrEn), .clrMask(clrMask),
    .strb(strb), .flags(flags), .irqPulse(irqPulse)
  );

  alarmDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nowVec(nowVec), .hit(hit)
  );
endmodule

// File: tb/calAlarm_bench.sv
`timescale 1ns/1ps
module calAlarm_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [7:0] secNow = 0, minNow = 0, hourNow = 0, dateNow = 0, monNow = 0, dowNow = 0;
  logic wrEn = 1'b0;
  logic wrAlarm = 1'b0;
  logic [2:0] wrField = 0;
  logic [7:0] wrData = 0;
  logic clrEn = 1'b0;
  logic [1:0] clrMask = 0;
  logic [1:0] flags;
  logic irqPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  calAlarm u_calAlarm (
    .clk(clk), .rstN(rstN), .tick(tick), .secNow(secNow), .minNow(minNow),
    .hourNow(hourNow), .dateNow(dateNow), .monNow(monNow), .dowNow(dowNow),
    .wrEn(wrEn), .wrAlarm(wrAlarm), .wrField(wrField), .wrData(wrData),
    .clrEn(clrEn), .clrMask(clrMask), .flags(flags), .irqPulse(irqPulse)
  );

  // {sec, min, hour, date, month, dow, expected {flag1, flag0}}
  localparam logic [49:0] VECS [10] = '{
    {8'h00, 8'h30, 8'h11, 8'h01, 8'h01, 8'h03, 2'b01},
    {8'h59, 8'h29, 8'h11, 8'h01, 8'h01, 8'h03, 2'b00},
    {8'h15, 8'h29, 8'h11, 8'h01, 8'h01, 8'h03, 2'b10},
    {8'h15, 8'h44, 8'h07, 8'h22, 8'h09, 8'h05, 2'b10},
    {8'h00, 8'h30, 8'h11, 8'h02, 8'h01, 8'h04, 2'b00},
    {8'h00, 8'h30, 8'h11, 8'h01, 8'h01, 8'h06, 2'b01},
    {8'h00, 8'h31, 8'h11, 8'h01, 8'h01, 8'h03, 2'b00},
    {8'h16, 8'h30, 8'h11, 8'h01, 8'h01, 8'h03, 2'b00},
    {8'h00, 8'h30, 8'h12, 8'h01, 8'h01, 8'h03, 2'b00},
    {8'h00, 8'h30, 8'h11, 8'h01, 8'h02, 8'h03, 2'b00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [2:0] f, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAlarm = a; wrField = f; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input logic [47:0] t);
    {secNow, minNow, hourNow, dateNow, monNow, dowNow} = t;
  endtask

  // drive one tick; on return the registered results are visible
  task automatic doTick(input logic [47:0] t, input bit withClr, input logic [1:0] cm);
    @(negedge clk);
    setTime(t);
    tick = 1'b1; clrEn = withClr; clrMask = cm;
    @(negedge clk);
    tick = 1'b0; clrEn = 1'b0; clrMask = 2'b00;
  endtask

  task automatic clearFlags(input logic [1:0] cm);
    @(negedge clk);
    clrEn = 1'b1; clrMask = cm;
    @(negedge clk);
    clrEn = 1'b0; clrMask = 2'b00;
  endtask

  localparam logic [47:0] T_MATCH0 = {8'h00, 8'h30, 8'h11, 8'h01, 8'h01, 8'h03};
  localparam logic [47:0] T_OTHER  = {8'h42, 8'h10, 8'h05, 8'h09, 8'h07, 8'h02};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", {6'b0, flags}, 8'h00);
    chk("R1 irq after reset", {7'b0, irqPulse}, 8'h00);
    // all-zero time equals all-zero values, but every field is disabled
    doTick(48'h0, 0, 2'b00);
    chk("R1/R5 disabled after reset", {6'b0, flags}, 8'h00);

    // alarm 0: 11:30:00 on 1 January, dow left disabled, year stored
    writeReg(0, 3'd0, 8'h80);
    writeReg(0, 3'd1, 8'hB0);
    writeReg(0, 3'd2, 8'h91);
    writeReg(0, 3'd3, 8'h81);
    writeReg(0, 3'd4, 8'h81);
    writeReg(0, 3'd5, 8'h05);
    writeReg(0, 3'd6, 8'h25);
    // alarm 1: seconds 15 only (repeats every minute)
    writeReg(1, 3'd0, 8'h95);

    // R7: matching time without tick
    @(negedge clk);
    setTime(T_MATCH0);
    repeat (4) @(negedge clk);
    chk("R7 no tick no flag", {6'b0, flags}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      doTick(VECS[i][49:2], 0, 2'b00);
      chk($sformatf("R3/R4/R2 vector %0d flags", i), {6'b0, flags}, {6'b0, VECS[i][1:0]});
      chk($sformatf("R10 vector %0d irq", i), {7'b0, irqPulse}, {7'b0, |VECS[i][1:0]});
      clearFlags(2'b11);
      chk($sformatf("R8 vector %0d cleared", i), {6'b0, flags}, 8'h00);
    end

    // R10: the pulse lasts one cycle
    doTick(T_MATCH0, 0, 2'b00);
    chk("R10 irq high", {7'b0, irqPulse}, 8'h01);
    @(negedge clk);
    chk("R10 irq one cycle", {7'b0, irqPulse}, 8'h00);
    // R8: sticky across non-matching ticks
    doTick(T_OTHER, 0, 2'b00);
    doTick(T_OTHER, 0, 2'b00);
    chk("R8 sticky flags", {6'b0, flags}, 8'h01);
    chk("R10 no irq on miss", {7'b0, irqPulse}, 8'h00);
    clearFlags(2'b10);
    chk("R8 masked clear keeps flag0", {6'b0, flags}, 8'h01);
    clearFlags(2'b01);
    chk("R8 clear flag0", {6'b0, flags}, 8'h00);

    // R9: match with simultaneous clear
    doTick(T_MATCH0, 0, 2'b00);
    doTick(T_MATCH0, 1, 2'b01);
    chk("R9 match beats clear", {6'b0, flags}, 8'h01);
    clearFlags(2'b11);

    // R6: year changed, still matches
    writeReg(0, 3'd6, 8'h99);
    doTick(T_MATCH0, 0, 2'b00);
    chk("R6 year ignored", {6'b0, flags}, 8'h01);
    clearFlags(2'b11);

    // R11: both alarms match on the same tick
    writeReg(1, 3'd0, 8'h80);
    doTick(T_MATCH0, 0, 2'b00);
    chk("R11 both flags", {6'b0, flags}, 8'h03);
    clearFlags(2'b01);
    chk("R11 independent clear", {6'b0, flags}, 8'h02);
    clearFlags(2'b11);

    // R5: alarm 1 with no field enabled
    writeReg(1, 3'd0, 8'h00);
    doTick(T_MATCH0, 0, 2'b00);
    chk("R5 empty alarm silent", {6'b0, flags}, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule